// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block turns one compressed stack-frame macro instruction into a series of single micro-operations for a simple in-order pipeline. The request has an operation kind (save-and-allocate, restore-and-free, restore-free-and-return, or restore-free-return-with-zero), a 4-bit register-list selector and a stack adjustment in bytes. The block takes the request over a valid/ready handshake when it is idle. It then issues one micro-op for each cycle in which the consumer accepts one.

Register transfers come first. Each is a store or a load with a register index and a byte offset from the current stack pointer. They always walk the same descending register order. One stack-pointer add follows the transfers. The restore kinds then add a zero write to a0 and a return jump, as their kind requires. A bad selector or a bad adjustment is flagged on the accepting cycle. Such a request is consumed without emitting anything.

Top module: `stack_seq`

## Requirements
- R1: `req_ready` is high exactly when no sequence is in progress. It is high out of reset. A request is taken only on a cycle with `req_valid` and `req_ready` both high.
- R2: Selector codes 0 to 3 are illegal. Such a request raises `req_illegal` in the accepting cycle, emits no micro-op and leaves `req_ready` high.
- R3: Only multiples of 16 are legal adjustments, from 16 up to 112 when XLEN is 32 and up to 160 when XLEN is 64. Any other value is flagged and dropped as in R2.
- R4: Selector code 4 transfers x1 only. Code c from 5 to 14 transfers x1 and the first c-4 saved registers in the order x8, x9, x18, x19 and upward. Code 15 transfers all 13 registers, so c-3 registers for 5 to 14 and 13 for 15.
- R5: Transfers run in the fixed order x27, x26, ..., x18, x9, x8, x1, skipping any register not in the set.
- R6: Kind 0 (save) emits stores (op 0). The first is at offset -W and each later one is W lower, where W is XLEN/8.
- R7: Kinds 1, 2 and 3 emit loads (op 1). The first is at offset adj-W and each later one is W lower.
- R8: After the last transfer, a stack-pointer add (op 2, register field 2) carries -adj for kind 0 and +adj for the other kinds.
- R9: Kind 3 emits zero-to-a0 (op 3, register 10, imm 0), then the add, then return (op 4, register 1, imm 0). Kind 2 emits the add, then return. Kind 1 ends with the add.
- R10: While `uop_valid` is high and `uop_ready` is low, the valid, op, register and imm outputs keep their values into the next cycle.
- R11: `seq_done` is high exactly in the cycle the final micro-op of a sequence is accepted. The block is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Macro request present |
| req_kind | input | 2 | 0 save, 1 restore, 2 restore+return, 3 restore+zero+return |
| req_rlist | input | 4 | Register-list selector, codes 4..15 legal |
| req_adj | input | ADJ_W | Stack adjustment in bytes |
| req_ready | output | 1 | Idle, can take a request |
| req_illegal | output | 1 | Accepted request was illegal |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_op | output | 3 | 0 store, 1 load, 2 sp add, 3 zero a0, 4 return |
| uop_reg | output | 5 | Register index |
| uop_imm | output | IMM_W | Signed offset from sp, or sp increment |
| seq_done | output | 1 | Final micro-op accepted this cycle |

## Verification
A corrupted position counter shows up on the very next accepted transfer as a wrong register index, a missing register or an extra one. A running offset that drifts appears as a wrong address on the next store or load. A wrong phase or kind register causes a missing or extra tail micro-op, or a sign error on the stack add, within at most three accepted micro-ops. Random consumer stalls check that the held micro-op never shifts. They also check that `seq_done` lines up with the final accept and that the block goes back to idle one cycle later.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [1:0] {
        K_SAVE     = 2'd0,
        K_REST     = 2'd1,
        K_REST_RET = 2'd2,
        K_REST_RZ  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        U_STORE = 3'd0,
        U_LOAD  = 3'd1,
        U_SPADD = 3'd2,
        U_ZERO  = 3'd3,
        U_RET   = 3'd4
    } uop_e;

    typedef enum logic [1:0] {
        PH_XFER = 2'd0,
        PH_ZERO = 2'd1,
        PH_SP   = 2'd2,
        PH_RET  = 2'd3
    } phase_e;

    localparam int NSLOT     = 13;
    localparam int LAST_SLOT = NSLOT - 1;

    // slot 0 is transferred first; the set for a selector is always a suffix
    function automatic logic [4:0] slot_reg(input logic [3:0] slot);
        logic [4:0] r;
        if (slot < 4'd10)       r = 5'd27 - 5'(slot);
        else if (slot == 4'd10) r = 5'd9;
        else if (slot == 4'd11) r = 5'd8;
        else                    r = 5'd1;
        return r;
    endfunction

endpackage

// File: rtl/frame_decode.sv
module frame_decode
    import stack_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int ADJ_W = 8
) (
    input  logic [3:0]       rlist,
    input  logic [ADJ_W-1:0] adj,
    output logic             legal,
    output logic [3:0]       first_slot
);
    localparam int MAX_ADJ = (XLEN == 64) ? 160 : 112;

    logic rlist_ok;
    logic adj_ok;

    always_comb begin
        rlist_ok = (rlist >= 4'd4);
        adj_ok   = (adj[3:0] == 4'd0) && (adj != '0) && (int'(adj) <= MAX_ADJ);
        legal    = rlist_ok && adj_ok;
        if (rlist == 4'd4)       first_slot = 4'(LAST_SLOT);
        else if (rlist == 4'd15) first_slot = 4'd0;
        else                     first_slot = 4'd0 - rlist;  // 16 - code
    end

endmodule

// File: rtl/uop_walker.sv
module uop_walker
    import stack_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int ADJ_W = 8,
    parameter int IMM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  kind_e            start_kind,
    input  logic [ADJ_W-1:0] start_adj,
    input  logic [3:0]       start_slot,
    input  logic             uop_ready,
    output logic             busy,
    output logic             uop_valid,
    output uop_e             uop_op,
    output logic [4:0]       uop_reg,
    output logic [IMM_W-1:0] uop_imm,
    output logic             seq_done
);
    localparam int WB = XLEN / 8;
    localparam logic [IMM_W-1:0] WB_I = IMM_W'(WB);

    typedef struct packed {
        logic             busy;
        kind_e            kind;
        logic [ADJ_W-1:0] adj;
        logic [3:0]       slot;
        phase_e           phase;
        logic [IMM_W-1:0] off;
    } walk_t;

    walk_t st_q, st_d;
    logic  last;
    logic  fire;
    logic  has_ret;

    always_comb begin
        has_ret = (st_q.kind == K_REST_RET) || (st_q.kind == K_REST_RZ);
        last    = (st_q.phase == PH_RET) || ((st_q.phase == PH_SP) && !has_ret);
        fire    = st_q.busy && uop_ready;

        uop_valid = st_q.busy;
        uop_op    = U_RET;
        uop_reg   = 5'd1;
        uop_imm   = '0;
        unique case (st_q.phase)
            PH_XFER: begin
                uop_op  = (st_q.kind == K_SAVE) ? U_STORE : U_LOAD;
                uop_reg = slot_reg(st_q.slot);
                uop_imm = st_q.off;
            end
            PH_ZERO: begin
                uop_op  = U_ZERO;
                uop_reg = 5'd10;
            end
            PH_SP: begin
                uop_op  = U_SPADD;
                uop_reg = 5'd2;
                uop_imm = (st_q.kind == K_SAVE) ? (IMM_W'(0) - IMM_W'(st_q.adj))
                                                : IMM_W'(st_q.adj);
            end
            default: begin
                uop_op  = U_RET;
                uop_reg = 5'd1;
            end
        endcase
        seq_done = fire && last;

        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.kind  = start_kind;
                st_d.adj   = start_adj;
                st_d.slot  = start_slot;
                st_d.phase = PH_XFER;
                st_d.off   = (start_kind == K_SAVE) ? (IMM_W'(0) - WB_I)
                                                    : (IMM_W'(start_adj) - WB_I);
            end
        end else if (fire) begin
            unique case (st_q.phase)
                PH_XFER: begin
                    if (st_q.slot == 4'(LAST_SLOT)) begin
                        st_d.phase = (st_q.kind == K_REST_RZ) ? PH_ZERO : PH_SP;
                    end else begin
                        st_d.slot = st_q.slot + 4'd1;
                        st_d.off  = st_q.off - WB_I;
                    end
                end
                PH_ZERO: st_d.phase = PH_SP;
                PH_SP: begin
                    if (has_ret) st_d.phase = PH_RET;
                    else         st_d.busy  = 1'b0;
                end
                default: st_d.busy = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, kind: K_SAVE, adj: '0, slot: '0,
                      phase: PH_XFER, off: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

    // R10
    uop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_op)
                                       && $stable(uop_reg) && $stable(uop_imm)));

    // R6 R7
    offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.phase == PH_XFER) |=>
            (st_q.phase != PH_XFER) || (uop_imm == $past(uop_imm) - WB_I));

    // R5
    reg_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.phase == PH_XFER) |=>
            (st_q.phase != PH_XFER) || (uop_reg < $past(uop_reg)));

    // R9
    ret_follows_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && uop_op == U_SPADD && has_ret) |=> (uop_valid && uop_op == U_RET));

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !uop_valid);

endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int ADJ_W = 8,
    parameter int IMM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [3:0]       req_rlist,
    input  logic [ADJ_W-1:0] req_adj,
    output logic             req_ready,
    output logic             req_illegal,
    output logic             uop_valid,
    input  logic             uop_ready,
    output logic [2:0]       uop_op,
    output logic [4:0]       uop_reg,
    output logic [IMM_W-1:0] uop_imm,
    output logic             seq_done
);
    logic       legal;
    logic [3:0] first_slot;
    logic       busy;
    logic       accept;
    logic       start;
    uop_e       op_e;

    frame_decode #(.XLEN(XLEN), .ADJ_W(ADJ_W)) u_dec (
        .rlist      (req_rlist),
        .adj        (req_adj),
        .legal      (legal),
        .first_slot (first_slot)
    );

    always_comb begin
        req_ready   = !busy;
        accept      = req_valid && req_ready;
        start       = accept && legal;
        req_illegal = accept && !legal;
    end

    uop_walker #(.XLEN(XLEN), .ADJ_W(ADJ_W), .IMM_W(IMM_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_kind (kind_e'(req_kind)),
        .start_adj  (req_adj),
        .start_slot (first_slot),
        .uop_ready  (uop_ready),
        .busy       (busy),
        .uop_valid  (uop_valid),
        .uop_op     (op_e),
        .uop_reg    (uop_reg),
        .uop_imm    (uop_imm),
        .seq_done   (seq_done)
    );

    assign uop_op = op_e;

    // R2 R3
    illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_illegal |=> (req_ready && !uop_valid));

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_illegal) |=> (!req_ready && uop_valid));

endmodule

// File: tb/stack_seq_test.sv
`timescale 1ns/100ps
module stack_seq_test;
    localparam int XLEN  = 32;
    localparam int ADJ_W = 8;
    localparam int IMM_W = 12;
    localparam int WB    = XLEN / 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_kind = '0;
    logic [3:0]       req_rlist = '0;
    logic [ADJ_W-1:0] req_adj = '0;
    logic             req_ready;
    logic             req_illegal;
    logic             uop_valid;
    logic             uop_ready = 1'b0;
    logic [2:0]       uop_op;
    logic [4:0]       uop_reg;
    logic [IMM_W-1:0] uop_imm;
    logic             seq_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int        e_n;
    logic [2:0] e_op [0:15];
    logic [4:0] e_reg[0:15];
    logic [IMM_W-1:0] e_imm[0:15];
    string     e_tag[0:15];

    always #2.5 clk = ~clk;

    stack_seq #(.XLEN(XLEN), .ADJ_W(ADJ_W), .IMM_W(IMM_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_rlist(req_rlist), .req_adj(req_adj), .req_ready(req_ready),
        .req_illegal(req_illegal), .uop_valid(uop_valid), .uop_ready(uop_ready),
        .uop_op(uop_op), .uop_reg(uop_reg), .uop_imm(uop_imm), .seq_done(seq_done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int xfer_count(input int code);
        if (code < 4) return 0;
        if (code == 15) return 13;
        return code - 3;
    endfunction

    function automatic int order_reg(input int pos);
        if (pos < 10) return 27 - pos;
        if (pos == 10) return 9;
        if (pos == 11) return 8;
        return 1;
    endfunction

    function automatic bit adj_legal(input int adj);
        int mx = (XLEN == 64) ? 160 : 112;
        return (adj % 16 == 0) && adj >= 16 && adj <= mx;
    endfunction

    task automatic build(input int kind, input int code, input int adj);
        int n = xfer_count(code);
        e_n = 0;
        for (int i = 0; i < n; i++) begin
            e_op[e_n]  = (kind == 0) ? 3'd0 : 3'd1;
            e_reg[e_n] = 5'(order_reg(13 - n + i));
            e_imm[e_n] = IMM_W'(((kind == 0) ? 0 : adj) - (i + 1) * WB);
            e_tag[e_n] = (kind == 0) ? "R6" : "R7";
            e_n++;
        end
        if (kind == 3) begin
            e_op[e_n] = 3'd3; e_reg[e_n] = 5'd10; e_imm[e_n] = '0; e_tag[e_n] = "R9"; e_n++;
        end
        e_op[e_n]  = 3'd2; e_reg[e_n] = 5'd2;
        e_imm[e_n] = IMM_W'((kind == 0) ? -adj : adj);
        e_tag[e_n] = "R8"; e_n++;
        if (kind >= 2) begin
            e_op[e_n] = 3'd4; e_reg[e_n] = 5'd1; e_imm[e_n] = '0; e_tag[e_n] = "R9"; e_n++;
        end
    endtask

    task automatic run_req(input int kind, input int code, input int adj, input int stall_pct);
        bit legal = (code >= 4) && adj_legal(adj);
        bit stalled = 0;
        logic [2:0] s_op; logic [4:0] s_reg; logic [IMM_W-1:0] s_imm;
        int k = 0;
        int guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(kind); req_rlist = 4'(code); req_adj = ADJ_W'(adj);
        uop_ready = 1'b0;
        #1;
        check(req_ready == 1'b1, "R1 ready before request", req_ready, 1);
        check(req_illegal == !legal, (code < 4) ? "R2 illegal flag" : "R3 illegal flag",
              req_illegal, !legal);
        @(negedge clk);
        req_valid = 1'b0;
        if (!legal) begin
            #1;
            check(req_ready && !uop_valid, (code < 4) ? "R2 no micro-op" : "R3 no micro-op",
                  uop_valid, 0);
            return;
        end
        build(kind, code, adj);
        #1;
        check(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
        while (k < e_n && guard < 2000) begin
            guard++;
            uop_ready = (($urandom % 100) >= stall_pct);
            #1;
            if (stalled) begin
                check(uop_op == s_op && uop_reg == s_reg && uop_imm == s_imm,
                      "R10 held micro-op", {uop_op, uop_reg, uop_imm}, {s_op, s_reg, s_imm});
            end
            check(uop_valid == 1'b1, "R4 micro-op present", uop_valid, 1);
            if (uop_ready) begin
                check(uop_op == e_op[k], "R4 op kind", uop_op, e_op[k]);
                check(uop_reg == e_reg[k], (e_op[k] <= 1) ? "R5 register" : e_tag[k],
                      uop_reg, e_reg[k]);
                check(uop_imm == e_imm[k], e_tag[k], $signed(uop_imm), $signed(e_imm[k]));
                check(seq_done == (k == e_n - 1), "R11 done pulse", seq_done, k == e_n - 1);
                k++;
                stalled = 0;
            end else begin
                check(seq_done == 1'b0, "R11 no done while stalled", seq_done, 0);
                s_op = uop_op; s_reg = uop_reg; s_imm = uop_imm;
                stalled = 1;
            end
            @(negedge clk);
        end
        uop_ready = 1'b0;
        #1;
        check(!uop_valid && req_ready, "R11 idle after done", uop_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        check(uop_valid == 1'b0 && seq_done == 1'b0, "R1 reset idle", uop_valid, 0);

        // directed corners
        run_req(1, 15, 64, 0);    // R4 all thirteen registers, plain restore
        run_req(0, 4, 16, 0);     // R4 ra only, save
        run_req(3, 14, 112, 30);  // R9 zero + return, R3 top legal adj
        run_req(2, 5, 32, 50);    // R9 return tail
        run_req(0, 15, 112, 70);  // R6 full save with stalls
        run_req(1, 3, 32, 0);     // R2 code 3
        run_req(0, 0, 16, 0);     // R2 code 0
        run_req(2, 8, 128, 0);    // R3 beyond 32-bit limit
        run_req(1, 8, 0, 0);      // R3 zero adjustment
        run_req(3, 8, 20, 0);     // R3 not a multiple of 16

        for (int i = 0; i < 300; i++) begin
            int kind = $urandom % 4;
            int code = $urandom % 16;
            int adj  = (($urandom % 8) == 0) ? int'($urandom % 256) : int'((($urandom % 7) + 1) * 16);
            run_req(kind, code, adj, $urandom % 60);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule